// File: doc/BRIEF.md
# Luma Edge Boost with Inverse Colour Transform

This block rebuilds an RGB pixel stream after edge detection has run on the luma plane. Each accepted cycle carries one pixel as 8-bit Y, U and V, together with an 8-bit edge strength. The edge strength is the sum of the absolute horizontal and vertical gradients, already limited to 255, and is aligned with that pixel. The block adds the edge strength to Y and saturates the sum. It then converts the brightened luma and the untouched chroma back to 8-bit red, green and blue using Q8 fixed-point coefficients. Each channel is clamped to the unsigned 8-bit range.

Edges therefore become brighter while hue stays as it was. The block sits between a gradient stage and a pixel sink. It accepts a pixel on any cycle where the input valid is high. It returns the matching result exactly two cycles later, with no back-pressure.

Top module: `luma_boost_rgb`

## Requirements
- R1: While reset is low at a rising edge, and on the first output after it, `out_valid`, `r_out`, `g_out` and `b_out` are all 0.
- R2: `out_valid` equals `in_valid` delayed by two clock cycles. Each pixel accepted with `in_valid` high produces exactly one result, two cycles later, in input order, and back-to-back pixels are supported.
- R3: The boosted luma is Yb = min(Y + E, 255), where E is `edge_in`.
- R4: `r_out` = clamp(Yb + floor((359·(V−128) + 128) / 256)).
- R5: `g_out` = clamp(Yb − floor((88·(U−128) + 183·(V−128) + 128) / 256)).
- R6: `b_out` = clamp(Yb + floor((453·(U−128) + 128) / 256)).
- R7: clamp() maps values below 0 to 0 and values above 255 to 255, independently for each of the three channels.
- R8: With neutral chroma (U = V = 128), all three outputs equal Yb. In particular, E = 255 gives R = G = B = 255, and E = 0 gives R = G = B = Y.
- R9: Inputs presented while `in_valid` is low are ignored. While `out_valid` is low, `r_out`, `g_out` and `b_out` keep the last result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Input pixel is valid this cycle |
| y_in | input | 8 | Luma sample |
| u_in | input | 8 | Blue-difference chroma, offset 128 |
| v_in | input | 8 | Red-difference chroma, offset 128 |
| edge_in | input | 8 | Clipped gradient magnitude for this pixel |
| out_valid | output | 1 | Result pixel is valid this cycle |
| r_out | output | 8 | Red result |
| g_out | output | 8 | Green result |
| b_out | output | 8 | Blue result |

## Verification
Neutral-chroma pixels with edge strengths of 0 and 255 separate the luma path from the matrix: any chroma leakage breaks R = G = B. Extreme chroma values push each channel past both rails, one at a time, which exposes a wrong coefficient, sign, rounding or clamp direction on a single channel. A pseudo-random back-to-back stream checks ordering and the two-cycle latency. Bubbles filled with junk inputs show that the outputs hold and that invalid data never enters the pipeline.

// File: rtl/lbr_pkg.sv
package lbr_pkg;
    // pixel width and fixed-point format
    parameter int PIX_W     = 8;
    parameter int FRAC_W    = 8;
    parameter int COEF_W    = 11;
    // Q8 coefficients of the inverse transform
    parameter int K_V_TO_R  = 359;
    parameter int K_U_TO_G  = 88;
    parameter int K_V_TO_G  = 183;
    parameter int K_U_TO_B  = 453;

    localparam int DIF_W    = PIX_W + 1;
    localparam int ACC_W    = DIF_W + COEF_W + 2;
    localparam int OFF_W    = ACC_W - FRAC_W;
    localparam int SUM_W    = OFF_W + 1;
    localparam int PIX_MAX  = (1 << PIX_W) - 1;
    localparam int MID      = 1 << (PIX_W - 1);

    typedef struct packed {
        logic                    vld;
        logic [PIX_W-1:0]        yb;
        logic signed [DIF_W-1:0] du;
        logic signed [DIF_W-1:0] dv;
    } stage1_t;

    typedef struct packed {
        logic             vld;
        logic [PIX_W-1:0] r;
        logic [PIX_W-1:0] g;
        logic [PIX_W-1:0] b;
    } stage2_t;
endpackage

// File: rtl/lbr_luma_add.sv
module lbr_luma_add #(
    parameter int PIX_W = 8
) (
    input  logic [PIX_W-1:0] y,
    input  logic [PIX_W-1:0] edge_mag,
    output logic [PIX_W-1:0] yb
);
    logic [PIX_W:0] wide;

    always_comb begin
        wide = {1'b0, y} + {1'b0, edge_mag};
        yb   = wide[PIX_W] ? {PIX_W{1'b1}} : wide[PIX_W-1:0];
    end
endmodule

// File: rtl/lbr_chroma_mix.sv
module lbr_chroma_mix #(
    parameter int DIF_W  = 9,
    parameter int ACC_W  = 22,
    parameter int FRAC_W = 8,
    parameter int K_VR   = 359,
    parameter int K_UG   = 88,
    parameter int K_VG   = 183,
    parameter int K_UB   = 453,
    localparam int OFF_W = ACC_W - FRAC_W
) (
    input  logic signed [DIF_W-1:0] du,
    input  logic signed [DIF_W-1:0] dv,
    output logic signed [OFF_W-1:0] r_off,
    output logic signed [OFF_W-1:0] g_off,
    output logic signed [OFF_W-1:0] b_off
);
    localparam logic signed [ACC_W-1:0] C_VR = ACC_W'(K_VR);
    localparam logic signed [ACC_W-1:0] C_UG = ACC_W'(K_UG);
    localparam logic signed [ACC_W-1:0] C_VG = ACC_W'(K_VG);
    localparam logic signed [ACC_W-1:0] C_UB = ACC_W'(K_UB);
    localparam logic signed [ACC_W-1:0] RND  = ACC_W'(1 << (FRAC_W - 1));

    logic signed [ACC_W-1:0] du_x, dv_x;
    logic signed [ACC_W-1:0] acc_r, acc_g, acc_b;

    always_comb begin
        du_x  = {{(ACC_W-DIF_W){du[DIF_W-1]}}, du};
        dv_x  = {{(ACC_W-DIF_W){dv[DIF_W-1]}}, dv};
        acc_r = C_VR * dv_x + RND;
        acc_g = C_UG * du_x + C_VG * dv_x + RND;
        acc_b = C_UB * du_x + RND;
        // dropping the fraction bits is a floor on two's complement
        r_off = acc_r[ACC_W-1:FRAC_W];
        g_off = acc_g[ACC_W-1:FRAC_W];
        b_off = acc_b[ACC_W-1:FRAC_W];
    end
endmodule

// File: rtl/lbr_clamp.sv
module lbr_clamp #(
    parameter int SUM_W = 15,
    parameter int PIX_W = 8
) (
    input  logic signed [SUM_W-1:0] sum,
    output logic [PIX_W-1:0]        pix
);
    localparam logic signed [SUM_W-1:0] TOP = SUM_W'((1 << PIX_W) - 1);

    always_comb begin
        if (sum[SUM_W-1])
            pix = '0;
        else if (sum > TOP)
            pix = {PIX_W{1'b1}};
        else
            pix = sum[PIX_W-1:0];
    end
endmodule

// File: rtl/luma_boost_rgb.sv
module luma_boost_rgb
    import lbr_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [PIX_W-1:0] y_in,
    input  logic [PIX_W-1:0] u_in,
    input  logic [PIX_W-1:0] v_in,
    input  logic [PIX_W-1:0] edge_in,
    output logic             out_valid,
    output logic [PIX_W-1:0] r_out,
    output logic [PIX_W-1:0] g_out,
    output logic [PIX_W-1:0] b_out
);
    localparam logic [DIF_W-1:0] MID_X = DIF_W'(MID);
    localparam int N_CH = 3;

    stage1_t s1_d, s1_q;
    stage2_t s2_d, s2_q;

    logic [PIX_W-1:0]        yb_w;
    logic signed [OFF_W-1:0] off_r, off_g, off_b;
    logic signed [SUM_W-1:0] ch_sum [N_CH];
    logic [PIX_W-1:0]        ch_pix [N_CH];
    logic signed [SUM_W-1:0] y_ext;

    lbr_luma_add #(.PIX_W(PIX_W)) i_luma (
        .y        (y_in),
        .edge_mag (edge_in),
        .yb       (yb_w)
    );

    lbr_chroma_mix #(
        .DIF_W (DIF_W), .ACC_W (ACC_W), .FRAC_W(FRAC_W),
        .K_VR  (K_V_TO_R), .K_UG(K_U_TO_G), .K_VG(K_V_TO_G), .K_UB(K_U_TO_B)
    ) i_mix (
        .du    (s1_q.du),
        .dv    (s1_q.dv),
        .r_off (off_r),
        .g_off (off_g),
        .b_off (off_b)
    );

    always_comb begin
        y_ext     = $signed({{(SUM_W-PIX_W){1'b0}}, s1_q.yb});
        ch_sum[0] = y_ext + {off_r[OFF_W-1], off_r};
        ch_sum[1] = y_ext - {off_g[OFF_W-1], off_g};
        ch_sum[2] = y_ext + {off_b[OFF_W-1], off_b};
    end

    for (genvar c = 0; c < N_CH; c++) begin : g_clamp
        lbr_clamp #(.SUM_W(SUM_W), .PIX_W(PIX_W)) i_clamp (
            .sum (ch_sum[c]),
            .pix (ch_pix[c])
        );
    end

    // next-state logic
    always_comb begin
        s1_d     = s1_q;
        s1_d.vld = in_valid;
        if (in_valid) begin
            s1_d.yb = yb_w;
            s1_d.du = $signed({1'b0, u_in} - MID_X);
            s1_d.dv = $signed({1'b0, v_in} - MID_X);
        end

        s2_d     = s2_q;
        s2_d.vld = s1_q.vld;
        if (s1_q.vld) begin
            s2_d.r = ch_pix[0];
            s2_d.g = ch_pix[1];
            s2_d.b = ch_pix[2];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_q <= '0;
            s2_q <= '0;
        end else begin
            s1_q <= s1_d;
            s2_q <= s2_d;
        end
    end

    assign out_valid = s2_q.vld;
    assign r_out     = s2_q.r;
    assign g_out     = s2_q.g;
    assign b_out     = s2_q.b;
endmodule

// File: rtl/lbr_checker.sv
module lbr_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       in_valid,
    input logic [7:0] y_in,
    input logic [7:0] u_in,
    input logic [7:0] v_in,
    input logic [7:0] edge_in,
    input logic       out_valid,
    input logic [7:0] r_out,
    input logic [7:0] g_out,
    input logic [7:0] b_out
);
    logic [1:0] warm;

    always_ff @(posedge clk) begin
        if (!rst_n)
            warm <= 2'd0;
        else if (warm != 2'd3)
            warm <= warm + 2'd1;
    end

    assert_reset_clear_R1: assert property (@(posedge clk)
        $past(!rst_n) |-> (!out_valid && r_out == 8'd0 && g_out == 8'd0 && b_out == 8'd0));

    assert_latency_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (warm >= 2'd2) |-> (out_valid == $past(in_valid, 2)));

    assert_grey_equal_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (warm >= 2'd2 && $past(in_valid, 2) && $past(u_in, 2) == 8'd128 && $past(v_in, 2) == 8'd128)
        |-> (r_out == g_out && g_out == b_out));

    assert_full_edge_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (warm >= 2'd2 && $past(in_valid, 2) && $past(edge_in, 2) == 8'hff
         && $past(u_in, 2) == 8'd128 && $past(v_in, 2) == 8'd128)
        |-> (r_out == 8'hff));

    assert_hold_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (warm >= 2'd1 && !out_valid) |-> ($stable(r_out) && $stable(g_out) && $stable(b_out)));
endmodule

bind luma_boost_rgb lbr_checker i_lbr_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .y_in      (y_in),
    .u_in      (u_in),
    .v_in      (v_in),
    .edge_in   (edge_in),
    .out_valid (out_valid),
    .r_out     (r_out),
    .g_out     (g_out),
    .b_out     (b_out)
);

// File: tb/test_luma_boost_rgb.sv
`timescale 1ns/1ps
module test_luma_boost_rgb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       in_valid = 1'b0;
    logic [7:0] y_in = '0, u_in = '0, v_in = '0, edge_in = '0;
    logic       out_valid;
    logic [7:0] r_out, g_out, b_out;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 0;

    int py [16], pu [16], pv [16], pe [16];
    int seed = 32'h1d2c3b4a;

    always #2 clk = ~clk;

    luma_boost_rgb i_luma_boost_rgb (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
        .y_in(y_in), .u_in(u_in), .v_in(v_in), .edge_in(edge_in),
        .out_valid(out_valid), .r_out(r_out), .g_out(g_out), .b_out(b_out)
    );

    function automatic int clip(int x);
        return (x < 0) ? 0 : ((x > 255) ? 255 : x);
    endfunction

    // independent reference built from R3..R7
    function automatic void model(input int y, u, v, e, output int r, g, b);
        int yb, du, dv;
        yb = (y + e > 255) ? 255 : y + e;
        du = u - 128;
        dv = v - 128;
        r  = clip(yb + ((359 * dv + 128) >>> 8));
        g  = clip(yb - ((88 * du + 183 * dv + 128) >>> 8));
        b  = clip(yb + ((453 * du + 128) >>> 8));
    endfunction

    task automatic chk(string req, int act, int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int next_rand();
        seed = seed * 1103515245 + 12345;
        return (seed >>> 16) & 255;
    endfunction

    // drive n pixels back to back, check each result two cycles later
    task automatic run_burst(int n, string tag);
        int r, g, b;
        for (int i = 0; i < n + 2; i++) begin
            @(negedge clk);
            if (i >= 2) begin
                model(py[i-2], pu[i-2], pv[i-2], pe[i-2], r, g, b);
                chk({tag, " R2 valid"}, int'(out_valid), 1);
                chk({tag, " R4 red"},   int'(r_out), r);
                chk({tag, " R5 green"}, int'(g_out), g);
                chk({tag, " R6 blue"},  int'(b_out), b);
            end
            if (i < n) begin
                in_valid = 1'b1;
                y_in = 8'(py[i]); u_in = 8'(pu[i]); v_in = 8'(pv[i]); edge_in = 8'(pe[i]);
            end else begin
                in_valid = 1'b0;
            end
        end
        @(negedge clk);
        chk({tag, " R2 drained"}, int'(out_valid), 0);
    endtask

    task automatic set_px(int i, int y, int u, int v, int e);
        py[i] = y; pu[i] = u; pv[i] = v; pe[i] = e;
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        in_valid = 1'b1; y_in = 8'd200; u_in = 8'd10; v_in = 8'd250; edge_in = 8'd9;
        repeat (3) @(negedge clk);
        chk("R1 valid in reset", int'(out_valid), 0);
        chk("R1 red in reset",   int'(r_out), 0);
        chk("R1 green in reset", int'(g_out), 0);
        chk("R1 blue in reset",  int'(b_out), 0);
        in_valid = 1'b0;
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 valid after release", int'(out_valid), 0);
    endtask

    task automatic t_grey();
        set_px(0, 0, 128, 128, 0);
        set_px(1, 100, 128, 128, 0);
        set_px(2, 100, 128, 128, 255);
        set_px(3, 37, 128, 128, 60);
        set_px(4, 240, 128, 128, 100);
        run_burst(5, "grey R3 R8");
        // explicit R8: neutral chroma with full edge gives white
        set_px(0, 3, 128, 128, 255);
        run_burst(1, "white R8");
    endtask

    task automatic t_rails();
        set_px(0, 250, 128, 255, 0);   // red above 255
        set_px(1, 5, 128, 0, 0);       // red below 0
        set_px(2, 200, 255, 128, 0);   // blue above 255
        set_px(3, 20, 0, 128, 0);      // blue below 0
        set_px(4, 0, 255, 255, 0);     // green below 0
        set_px(5, 250, 0, 0, 0);       // green above 255
        set_px(6, 10, 255, 128, 0);    // blue inside range
        run_burst(7, "rails R7");
    endtask

    task automatic t_stream();
        for (int i = 0; i < 16; i++)
            set_px(i, next_rand(), next_rand(), next_rand(), next_rand() >> (i % 4));
        run_burst(16, "stream R2");
    endtask

    task automatic t_idle_hold();
        int r, g, b;
        model(60, 90, 170, 20, r, g, b);
        @(negedge clk);
        in_valid = 1'b1; y_in = 8'd60; u_in = 8'd90; v_in = 8'd170; edge_in = 8'd20;
        @(negedge clk);
        in_valid = 1'b0; y_in = 8'd255; u_in = 8'd0; v_in = 8'd255; edge_in = 8'd255;
        @(negedge clk);
        chk("R9 loaded red", int'(r_out), r);
        for (int k = 0; k < 4; k++) begin
            y_in = 8'(k * 50); u_in = 8'(255 - k); edge_in = 8'(k);
            @(negedge clk);
            chk("R9 idle valid", int'(out_valid), 0);
            chk("R9 red held",   int'(r_out), r);
            chk("R9 green held", int'(g_out), g);
            chk("R9 blue held",  int'(b_out), b);
        end
    endtask

    initial begin
        t_reset();
        t_grey();
        t_rails();
        t_stream();
        t_idle_hold();
        finished = 1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        #(4 * 50000);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected done");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end
endmodule